// File: doc/BRIEF.md
# Multilevel Vectored Interrupt Controller

This block sits beside a CPU core. It collects interrupt conditions from a parameterised set of sources and chooses the one the core should take next. Each source has an enable and a two-bit priority level. The block also receives a separate enable for each of the three levels and one global enable. Every source keeps a pending flag. The block raises `irq_o` together with a vector index while a request is eligible. When the core answers with a one-cycle `ack_i`, the block accepts the interrupt.

The block tracks nesting with one "executing" bit per level. A request can pre-empt the running handler only if its level is strictly above every executing level. An interrupt-return strobe from the core clears the most recently entered level. After an interrupt return, and after the global enable turns on, the core must retire an instruction before another interrupt is offered. A protected-write event blocks interrupts for a short fixed window.

Top module: `mlvic_top`

## Requirements
- R1: `irq_o` is never high while `gie_i` is low. Accepting an interrupt does not depend on, and does not change, the global enable.
- R2: A request whose level has its bit in `lvl_en_i` clear is never offered. Bit 0 enables low (1), bit 1 enables medium (2) and bit 2 enables high (3).
- R3: A source's flag is set in the cycle after its `cond_i` bit is high. This holds whether the source, its level or the global enable is on or off. When set and clear arrive in the same cycle, the set wins.
- R4: A one on `flag_clr_i` clears that flag. Accepting an interrupt clears the flag of the accepted source if it is auto-clearing. By default every source except the highest-numbered one auto-clears. The highest-numbered source keeps its flag until it is cleared by a write.
- R5: A request is offered only if its level is strictly higher than the highest level marked executing. Otherwise it stays pending.
- R6: `status_o` holds one executing bit per level (bit 0 low, bit 1 medium, bit 2 high) and is zero after reset. Accepting an interrupt sets the bit of the accepted level. `reti_i` clears the highest set bit. `ret_i` leaves the status unchanged.
- R7: After a cycle with `reti_i` high, or a cycle in which `gie_i` rises, no request is offered until a cycle with `retire_i` high has passed.
- R8: A cycle with `ccp_i` high blocks `irq_o` for the following four cycles.
- R9: `vec_o` is the offered source index plus one. It is 0 when `irq_o` is low, because vector 0 is reserved for reset.
- R10: Of several pending requests, the highest eligible level wins. Within that level, the lowest source index wins.
- R11: When `reti_i` and an accepted `ack_i` fall in the same cycle, the old top level is cleared and the new level is set.
- R12: A source whose `src_en_i` bit is clear, or whose level field is 0, is never offered, although its flag is still kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cond_i | input | NSRC | Raw interrupt conditions, one per source |
| flag_clr_i | input | NSRC | Write-one-to-clear strobes for the flags |
| src_en_i | input | NSRC | Per-source enable |
| src_lvl_i | input | 2*NSRC | Per-source level, 2 bits each (0 none, 1 low, 2 medium, 3 high) |
| lvl_en_i | input | 3 | Per-level enable |
| gie_i | input | 1 | Global interrupt enable |
| retire_i | input | 1 | An instruction retired this cycle |
| reti_i | input | 1 | Interrupt-return executed this cycle |
| ret_i | input | 1 | Ordinary subroutine return executed this cycle |
| ccp_i | input | 1 | Protected-write signature event |
| ack_i | input | 1 | CPU accepts the offered interrupt |
| irq_o | output | 1 | Interrupt offered to the CPU |
| vec_o | output | VEC_W | Offered vector index |
| status_o | output | 3 | Executing bit per level |
| flag_o | output | NSRC | Pending flags |

## Verification
Accepting a new interrupt and unwinding the current one can happen in the same cycle. The bench provokes this by keeping a low-level handler executing while it raises a medium-level condition. It then drives `ack_i` and `reti_i` together, and it expects only the medium bit to stay set in the status. A second coincidence is a condition and its write-one-to-clear strobe arriving in the same cycle, where the flag is expected to stay set. A behavioural model replays both cases, and a long random phase that drives all strobes freely, on every clock.

// File: rtl/mlvic_pkg.sv
package mlvic_pkg;
   localparam int NLVL  = 3;
   localparam int LVL_W = 2;
   typedef logic [LVL_W-1:0] lvl_t;
   typedef logic [NLVL-1:0]  lvl_mask_t;
endpackage

// File: rtl/mlvic_flags.sv
module mlvic_flags #(
   parameter int              NSRC     = 8,
   parameter logic [NSRC-1:0] AUTO_CLR = '1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] cond_i,
   input  logic [NSRC-1:0] clr_i,
   input  logic [NSRC-1:0] ack_hit_i,
   output logic [NSRC-1:0] flag_o
);
   logic [NSRC-1:0] flag_q;
   logic [NSRC-1:0] drop;

   assign drop   = clr_i | (ack_hit_i & AUTO_CLR);
   assign flag_o = flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= '0;
      else        flag_q <= (flag_q & ~drop) | cond_i;
   end

   AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (|cond_i) |=> ((flag_q & $past(cond_i)) == $past(cond_i))); // R3
   AST_ACK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (|(ack_hit_i & AUTO_CLR & ~cond_i)) |=> ((flag_q & $past(ack_hit_i & AUTO_CLR & ~cond_i)) == '0)); // R4
endmodule

// File: rtl/mlvic_arb.sv
module mlvic_arb
   import mlvic_pkg::*;
#(
   parameter int NSRC  = 8,
   parameter int SRC_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
   input  logic [NSRC-1:0]       flag_i,
   input  logic [NSRC-1:0]       src_en_i,
   input  logic [LVL_W*NSRC-1:0] src_lvl_i,
   input  lvl_mask_t             lvl_en_i,
   input  lvl_t                  top_i,
   output logic                  found_o,
   output lvl_t                  lvl_o,
   output logic [SRC_W-1:0]      src_o
);
   logic [NSRC-1:0] pend [NLVL+1];

   assign pend[0] = '0;
   for (genvar l = 1; l <= NLVL; l++) begin : g_lvl
      for (genvar s = 0; s < NSRC; s++) begin : g_src
         assign pend[l][s] = flag_i[s] & src_en_i[s]
                           & (src_lvl_i[LVL_W*s +: LVL_W] == lvl_t'(l));
      end
   end

   always_comb begin
      found_o = 1'b0;
      lvl_o   = '0;
      for (int l = NLVL; l >= 1; l--) begin
         if (!found_o && (lvl_t'(l) > top_i) && lvl_en_i[l-1] && (|pend[l])) begin
            found_o = 1'b1;
            lvl_o   = lvl_t'(l);
         end
      end
   end

   always_comb begin
      src_o = '0;
      for (int s = NSRC-1; s >= 0; s--) begin
         if (pend[lvl_o][s]) src_o = SRC_W'(s);
      end
   end
endmodule

// File: rtl/mlvic_gate.sv
module mlvic_gate #(
   parameter int BLACKOUT = 4,
   parameter int CNT_W    = $clog2(BLACKOUT + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic gie_i,
   input  logic retire_i,
   input  logic reti_i,
   input  logic ccp_i,
   output logic open_o
);
   logic             gie_q;
   logic             gap_q;
   logic [CNT_W-1:0] blk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gie_q <= 1'b0;
         gap_q <= 1'b0;
         blk_q <= '0;
      end else begin
         gie_q <= gie_i;
         if (reti_i || (gie_i && !gie_q)) gap_q <= 1'b1;
         else if (retire_i)               gap_q <= 1'b0;
         if (ccp_i)                       blk_q <= CNT_W'(BLACKOUT);
         else if (blk_q != '0)            blk_q <= blk_q - 1'b1;
      end
   end

   assign open_o = !gap_q && (blk_q == '0);

   AST_CCP_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      ccp_i |=> !open_o); // R8
   AST_RETI_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      reti_i |=> !open_o); // R7
endmodule

// File: rtl/mlvic_nest.sv
module mlvic_nest
   import mlvic_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      ack_go_i,
   input  lvl_t      ack_lvl_i,
   input  logic      reti_i,
   input  logic      ret_i,
   output lvl_mask_t stat_o,
   output lvl_t      top_o
);
   lvl_mask_t stat_q;
   lvl_mask_t clr_m;
   lvl_mask_t set_m;

   always_comb begin
      top_o = '0;
      for (int l = 1; l <= NLVL; l++) begin
         if (stat_q[l-1]) top_o = lvl_t'(l);
      end
   end

   assign clr_m  = (reti_i && top_o != '0) ? (lvl_mask_t'(1) << (top_o - lvl_t'(1))) : '0;
   assign set_m  = (ack_go_i && ack_lvl_i != '0) ? (lvl_mask_t'(1) << (ack_lvl_i - lvl_t'(1))) : '0;
   assign stat_o = stat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q <= '0;
      else        stat_q <= (stat_q & ~clr_m) | set_m;
   end

   AST_RET_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_i && !reti_i && !ack_go_i) |=> $stable(stat_q)); // R6
   AST_RETI_POPS: assert property (@(posedge clk) disable iff (!rst_n)
      (reti_i && !ack_go_i && stat_q != '0) |=> ($countones(stat_q) == $countones($past(stat_q)) - 1)); // R6
   AST_ACK_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_go_i && !reti_i) |=> ($countones(stat_q) == $countones($past(stat_q)) + 1)); // R6
endmodule

// File: rtl/mlvic_top.sv
module mlvic_top
   import mlvic_pkg::*;
#(
   parameter int              NSRC     = 8,
   parameter int              BLACKOUT = 4,
   parameter logic [NSRC-1:0] AUTO_CLR = {1'b0, {(NSRC-1){1'b1}}},
   parameter int              VEC_W    = $clog2(NSRC + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NSRC-1:0]       cond_i,
   input  logic [NSRC-1:0]       flag_clr_i,
   input  logic [NSRC-1:0]       src_en_i,
   input  logic [LVL_W*NSRC-1:0] src_lvl_i,
   input  logic [NLVL-1:0]       lvl_en_i,
   input  logic                  gie_i,
   input  logic                  retire_i,
   input  logic                  reti_i,
   input  logic                  ret_i,
   input  logic                  ccp_i,
   input  logic                  ack_i,
   output logic                  irq_o,
   output logic [VEC_W-1:0]      vec_o,
   output logic [NLVL-1:0]       status_o,
   output logic [NSRC-1:0]       flag_o
);
   localparam int SRC_W = (NSRC > 1) ? $clog2(NSRC) : 1;

   if (NSRC < 2 || NSRC > 64) begin : g_bad_nsrc
      $error("mlvic_top: NSRC must lie in 2..64");
   end
   if (BLACKOUT < 1) begin : g_bad_blk
      $error("mlvic_top: BLACKOUT must be at least 1");
   end

   logic             found;
   logic             open_w;
   logic             ack_go;
   lvl_t             win_lvl;
   lvl_t             top_lvl;
   logic [SRC_W-1:0] win_src;
   logic [NSRC-1:0]  ack_hit;

   mlvic_arb #(.NSRC(NSRC), .SRC_W(SRC_W)) u_arb (
      .flag_i(flag_o), .src_en_i(src_en_i), .src_lvl_i(src_lvl_i),
      .lvl_en_i(lvl_en_i), .top_i(top_lvl),
      .found_o(found), .lvl_o(win_lvl), .src_o(win_src));

   mlvic_gate #(.BLACKOUT(BLACKOUT)) u_gate (
      .clk(clk), .rst_n(rst_n), .gie_i(gie_i), .retire_i(retire_i),
      .reti_i(reti_i), .ccp_i(ccp_i), .open_o(open_w));

   assign irq_o   = gie_i && open_w && found;
   assign vec_o   = irq_o ? (VEC_W'(win_src) + VEC_W'(1)) : '0;
   assign ack_go  = ack_i && irq_o;
   assign ack_hit = ack_go ? (NSRC'(1) << win_src) : '0;

   mlvic_flags #(.NSRC(NSRC), .AUTO_CLR(AUTO_CLR)) u_flags (
      .clk(clk), .rst_n(rst_n), .cond_i(cond_i), .clr_i(flag_clr_i),
      .ack_hit_i(ack_hit), .flag_o(flag_o));

   mlvic_nest u_nest (
      .clk(clk), .rst_n(rst_n), .ack_go_i(ack_go), .ack_lvl_i(win_lvl),
      .reti_i(reti_i), .ret_i(ret_i), .stat_o(status_o), .top_o(top_lvl));

   AST_ABOVE_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (win_lvl > top_lvl)); // R5
   AST_IRQ_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> ((flag_o & src_en_i) != '0)); // R12
   AST_VEC_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (vec_o != '0)); // R9
endmodule

// File: tb/mlvic_top_bench.sv
module mlvic_top_bench;
   localparam int N = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  cond = '0, clr = '0, sen = '0;
   logic [2*N-1:0] slvl = '0;
   logic [2:0]    len = '0;
   logic          gie = 0, retire = 0, reti = 0, ret = 0, ccp = 0, ack = 0;
   logic          irq;
   logic [3:0]    vec;
   logic [2:0]    stat;
   logic [N-1:0]  flg;

   int total = 0, bad = 0;
   string cur = "R6";

   // reference state
   logic [N-1:0] m_flag = '0;
   logic [2:0]   m_stat = '0;
   bit           m_gap = 0, m_gq = 0;
   int           m_blk = 0;
   localparam logic [N-1:0] AUTO = 8'h7F;

   always #4 clk = ~clk;

   mlvic_top u_mlvic_top (
      .clk(clk), .rst_n(rst_n), .cond_i(cond), .flag_clr_i(clr), .src_en_i(sen),
      .src_lvl_i(slvl), .lvl_en_i(len), .gie_i(gie), .retire_i(retire),
      .reti_i(reti), .ret_i(ret), .ccp_i(ccp), .ack_i(ack),
      .irq_o(irq), .vec_o(vec), .status_o(stat), .flag_o(flg));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic mdl(output bit m_irq, output int m_vec, output int m_lvl,
                      output int m_src, output int m_top);
      bit f = 0;
      m_top = 0; m_lvl = 0; m_src = 0;
      for (int l = 1; l <= 3; l++) if (m_stat[l-1]) m_top = l;
      for (int l = 3; l >= 1; l--)
         if (!f && l > m_top && len[l-1])
            for (int s = 0; s < N; s++)
               if (!f && m_flag[s] && sen[s] && int'(slvl[2*s +: 2]) == l) begin
                  f = 1; m_lvl = l; m_src = s;
               end
      m_irq = f && gie && !m_gap && m_blk == 0;
      m_vec = m_irq ? m_src + 1 : 0;
   endtask

   task automatic tick();
      bit mi; int mv, ml, ms, mt;
      logic [N-1:0] nf;
      #1;
      mdl(mi, mv, ml, ms, mt);
      chk(irq === mi,     {cur, " irq"},    int'(irq),  int'(mi));
      chk(vec === 4'(mv), {cur, " vec"},    int'(vec),  mv);
      chk(stat === m_stat,{cur, " status"}, int'(stat), int'(m_stat));
      chk(flg === m_flag, {cur, " flags"},  int'(flg),  int'(m_flag));
      @(posedge clk);
      if (!rst_n) begin
         m_flag = '0; m_stat = '0; m_gap = 0; m_gq = 0; m_blk = 0;
      end else begin
         if (reti && mt > 0) m_stat[mt-1] = 1'b0;
         if (ack && mi) m_stat[ml-1] = 1'b1;
         nf = m_flag & ~clr;
         if (ack && mi && AUTO[ms]) nf[ms] = 1'b0;
         m_flag = nf | cond;
         if (reti || (gie && !m_gq)) m_gap = 1;
         else if (retire) m_gap = 0;
         m_gq = gie;
         m_blk = ccp ? 4 : (m_blk > 0 ? m_blk - 1 : 0);
      end
      #2;
   endtask

   task automatic pulse_cond(input int s);
      cond = '0; cond[s] = 1'b1; tick(); cond = '0;
   endtask
   task automatic do_ack();
      ack = 1; tick(); ack = 0;
   endtask
   task automatic do_reti();
      reti = 1; tick(); reti = 0; retire = 1; tick(); retire = 0;
   endtask

   initial begin
      #(8 * 200000);
      bad++; total++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) tick();
      rst_n = 1; tick();
      cur = "R6";
      chk(stat == 0 && irq == 0 && flg == 0, "R6 reset", int'(stat), 0);
      sen = '1;
      // s0..s2 low, s3..s4 medium, s5..s6 high, s7 low
      slvl = {2'd1, 2'd3, 2'd3, 2'd2, 2'd2, 2'd1, 2'd1, 2'd1};
      len = 3'b111;
      cur = "R1"; pulse_cond(0); tick();
      chk(flg[0] == 1'b1, "R3 flag while disabled", int'(flg), 1);
      chk(irq == 1'b0, "R1 no irq without gie", int'(irq), 0);
      cur = "R7"; gie = 1; tick(); tick();
      chk(irq == 1'b0, "R7 gap after enable", int'(irq), 0);
      retire = 1; tick(); retire = 0; #1;
      chk(irq == 1'b1 && vec == 4'd1, "R9 vector index plus one", int'(vec), 1);
      cur = "R2"; len = 3'b110; tick(); len = 3'b111;
      cur = "R12"; sen[0] = 0; tick(); sen[0] = 1;
      slvl[1:0] = 2'd0; tick(); slvl[1:0] = 2'd1;
      cur = "R10"; pulse_cond(1); tick(); #1;
      chk(vec == 4'd1, "R10 lowest index wins", int'(vec), 1);
      cur = "R4"; do_ack(); #1;
      chk(flg[0] == 1'b0 && flg[1] == 1'b1, "R4 auto clear on ack", int'(flg), 2);
      cur = "R5"; tick();
      chk(irq == 1'b0, "R5 same level stays pending", int'(irq), 0);
      pulse_cond(3); tick(); do_ack();
      pulse_cond(5); tick(); do_ack(); #1;
      chk(stat == 3'b111, "R6 nested levels", int'(stat), 7);
      cur = "R6"; ret = 1; tick(); ret = 0; #1;
      chk(stat == 3'b111, "R6 plain return ignored", int'(stat), 7);
      do_reti(); #1;
      chk(stat == 3'b011, "R6 reti pops top", int'(stat), 3);
      cur = "R7"; do_reti(); do_reti(); tick();
      cur = "R11"; do_ack(); pulse_cond(3); tick();
      ack = 1; reti = 1; tick(); ack = 0; reti = 0; #1;
      chk(stat == 3'b010, "R11 ack and reti together", int'(stat), 2);
      retire = 1; tick(); retire = 0;
      do_reti();
      cur = "R3"; gie = 0; pulse_cond(2); clr[2] = 1; tick(); clr = '0;
      cond[2] = 1; clr[2] = 1; tick(); cond = '0; clr = '0; #1;
      chk(flg[2] == 1'b1, "R3 set beats clear", int'(flg[2]), 1);
      cur = "R4"; clr = '1; tick(); clr = '0; #1;
      chk(flg == '0, "R4 write one clears", int'(flg), 0);
      gie = 1; tick(); retire = 1; tick(); retire = 0;
      pulse_cond(7); tick(); do_ack(); #1;
      chk(flg[7] == 1'b1, "R4 sticky flag survives ack", int'(flg[7]), 1);
      clr[7] = 1; tick(); clr = '0; do_reti();
      cur = "R8"; pulse_cond(0); tick();
      ccp = 1; tick(); ccp = 0;
      for (int k = 0; k < 4; k++) begin
         #1; chk(irq == 1'b0, "R8 blackout window", int'(irq), 0); tick();
      end
      #1; chk(irq == 1'b1, "R8 window ends", int'(irq), 1);
      cur = "R10";
      for (int c = 0; c < 1500; c++) begin
         cond = N'($urandom) & N'($urandom);
         clr = ($urandom % 8 == 0) ? N'($urandom) : '0;
         sen = N'($urandom) | N'($urandom);
         if ($urandom % 16 == 0) slvl = 16'($urandom);
         len = ($urandom % 4 == 0) ? 3'($urandom) : 3'b111;
         gie = ($urandom % 10) != 0;
         retire = $urandom % 2;
         reti = ($urandom % 6) == 0;
         ret = ($urandom % 6) == 0;
         ccp = ($urandom % 30) == 0;
         ack = $urandom % 2;
         tick();
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule